// File: doc/BRIEF.md
# Multimode Serial Port Controller

This block is a small serial port for a microcontroller-class subsystem. It has four framings. Mode 0 is a synchronous 8-bit shift, in which the block drives its own shift clock. Mode 1 is an asynchronous 10-bit frame. Modes 2 and 3 are asynchronous 11-bit frames that carry a ninth data bit. Software drives the port through a single write strobe that addresses either the control/status byte or the data buffer. It reads the control byte and the last received byte back on dedicated outputs.

Writing the data buffer starts a transmission. The asynchronous receiver watches the line whenever reception is enabled. A mode 0 receive shift starts when software writes the control byte with reception enabled and the receive flag clear. A 16x oversampling tick, generated outside the block, paces the asynchronous modes. In mode 0 the system clock is divided by one of two factors, selected by the multiprocessor bit. That same bit also drives two filters on received frames: address filtering on the ninth bit, and rejection of frames with a bad stop bit. An external select decides whether the top control bit shows the mode select or a sticky framing-error flag.

Top module: `sport_ctl`

## Requirements
- R1: After reset the control byte reads 0x00, the receive buffer reads 0x00, and both `txd` and `sclk` are high.
- R2: In mode 0 (control bits 7:6 = 00) one bit time lasts DIV_SLOW clocks when control bit 5 is 0 and DIV_FAST clocks when it is 1. `sclk` is low for the first half of each bit time, high for the second half, and high whenever no mode 0 shift is running.
- R3: A write to the data buffer in mode 0 shifts the byte out on `txd`, LSB first. The transmit flag (control bit 1) rises exactly 8 bit times after the write.
- R4: In mode 0, a control write with bit 4 = 1 and bit 0 = 0 starts an 8-bit receive. `rxd` is sampled as `sclk` rises, LSB first. After 8 bit times the byte appears in the receive buffer and the receive flag (control bit 0) rises.
- R5: In modes 1 to 3 a data write sends a start bit (0), 8 data bits LSB first, the ninth bit from control bit 3 (modes 2 and 3 only), then a stop bit (1). Each bit lasts OVS baud ticks, and `txd` idles high.
- R6: In the asynchronous modes the transmit flag rises as the stop bit begins. Hardware never clears the transmit or receive flag; a control write of 0 to the flag clears it.
- R7: In mode 1 with control bit 5 = 0, a received frame loads the buffer, stores its stop bit in control bit 2, and raises the receive flag partway through the stop bit.
- R8: In mode 1 with control bit 5 = 1, a frame whose stop bit is 0 leaves the receive flag and the buffer untouched. A frame with a good stop bit is accepted.
- R9: In modes 2 and 3 the received ninth bit goes to control bit 2. With control bit 5 = 1, a frame whose ninth bit is 0 leaves the flag and the buffer untouched.
- R10: A stop bit received as 0 sets a sticky framing flag. With `fe_sel` = 1, control bit 7 reads that flag and a write to bit 7 changes it, not the mode select. With `fe_sel` = 0, bit 7 reads the mode select.
- R11: With control bit 4 = 0 no frame is received: the receive flag and the buffer stay unchanged.
- R12: A start bit that reads high by majority vote of three mid-bit samples is discarded. The receiver then accepts the next frame normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 1 | Write target: 0 control byte, 1 data buffer |
| wr_data | input | 8 | Write value |
| fe_sel | input | 1 | 1: control bit 7 is the framing flag; 0: it is mode select bit 0 |
| baud_tick | input | 1 | One-cycle pulse at 16x the asynchronous bit rate |
| rxd | input | 1 | Serial data in |
| ctl_rd | output | 8 | Control/status byte |
| rx_buf | output | 8 | Last accepted received byte |
| txd | output | 1 | Serial data out |
| sclk | output | 1 | Mode 0 shift clock |

## Verification
The bench uses the default parameters: DIV_SLOW = 12, DIV_FAST = 4 and OVS = 16. It raises `baud_tick` on every fourth clock. With DIV_FAST = 4, a fast mode 0 shift fits in 32 cycles, so both divider settings are measured to the exact clock in one short run. With the dense tick, each 11-bit asynchronous frame fits in about 700 cycles. That leaves room for every framing, both filter rules, the framing flag, a disabled receiver and a false start.

// File: rtl/sport_pkg.sv
`timescale 1ns/1ps
package sport_pkg;
  typedef enum logic [1:0] {
    MODE_SHIFT  = 2'b00,
    MODE_UART8  = 2'b01,
    MODE_UART9F = 2'b10,
    MODE_UART9V = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_M0   = 2'd1,
    RX_ASY  = 2'd2
  } rx_st_e;
endpackage

// File: rtl/sport_shclk.sv
`timescale 1ns/1ps
module sport_shclk #(
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic fast,
  output logic mid,
  output logic last,
  output logic sclk
);
  localparam int CW = $clog2(DIV_SLOW + 1);
  localparam logic [CW-1:0] SLOW_L = CW'(DIV_SLOW - 1);
  localparam logic [CW-1:0] FAST_L = CW'(DIV_FAST - 1);
  localparam logic [CW-1:0] SLOW_H = CW'(DIV_SLOW / 2);
  localparam logic [CW-1:0] FAST_H = CW'(DIV_FAST / 2);
  localparam logic [CW-1:0] SLOW_M = CW'(DIV_SLOW / 2 - 1);
  localparam logic [CW-1:0] FAST_M = CW'(DIV_FAST / 2 - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim, hpt, mpt;

  assign lim = fast ? FAST_L : SLOW_L;
  assign hpt = fast ? FAST_H : SLOW_H;
  assign mpt = fast ? FAST_M : SLOW_M;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == lim) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign last = run && (cnt == lim);
  assign mid  = run && (cnt == mpt);
  assign sclk = !run || (cnt >= hpt);
endmodule

// File: rtl/sport_tx.sv
`timescale 1ns/1ps
module sport_tx
  import sport_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  mode_e      mode,
  input  logic [7:0] din,
  input  logic       bit9,
  input  logic       baud_tick,
  input  logic       m0_last,
  output logic       busy,
  output logic       m0_busy,
  output logic       txd,
  output logic       ti_set
);
  localparam int OW = $clog2(OVS);
  localparam logic [OW-1:0] T_LAST = OW'(OVS - 1);

  logic [10:0]   sh;
  logic [3:0]    left;
  logic [OW-1:0] tcnt;
  mode_e         md;
  logic          step;

  assign busy    = (left != 4'd0);
  assign m0_busy = busy && (md == MODE_SHIFT);
  assign step    = busy && ((md == MODE_SHIFT) ? m0_last : (baud_tick && tcnt == T_LAST));
  assign ti_set  = step && ((md == MODE_SHIFT) ? (left == 4'd1) : (left == 4'd2));
  assign txd     = sh[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '1;
      left <= '0;
      tcnt <= '0;
      md   <= MODE_SHIFT;
    end else if (start && !busy) begin
      md   <= mode;
      tcnt <= '0;
      case (mode)
        MODE_SHIFT: begin sh <= {3'b111, din};       left <= 4'd8;  end
        MODE_UART8: begin sh <= {2'b11, din, 1'b0};  left <= 4'd10; end
        default:    begin sh <= {1'b1, bit9, din, 1'b0}; left <= 4'd11; end
      endcase
    end else if (busy) begin
      if (md != MODE_SHIFT && baud_tick)
        tcnt <= (tcnt == T_LAST) ? '0 : tcnt + 1'b1;
      if (step) begin
        sh   <= {1'b1, sh[10:1]};
        left <= left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sport_rx.sv
`timescale 1ns/1ps
module sport_rx
  import sport_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ren,
  input  mode_e      mode,
  input  logic       sm2,
  input  logic       m0_start,
  input  logic       m0_mid,
  input  logic       m0_last,
  input  logic       baud_tick,
  input  logic       rxd,
  output logic       m0_busy,
  output logic       done,
  output logic [7:0] data,
  output logic       rb8_wr,
  output logic       rb8_val,
  output logic       fe_set
);
  localparam int OW = $clog2(OVS);
  localparam logic [OW-1:0] C_LAST = OW'(OVS - 1);
  localparam logic [OW-1:0] C_S0   = OW'(OVS / 2 - 1);
  localparam logic [OW-1:0] C_S1   = OW'(OVS / 2);
  localparam logic [OW-1:0] C_S2   = OW'(OVS / 2 + 1);

  rx_st_e        st;
  logic          s1, s2, v0, v1, n9;
  logic [OW-1:0] cnt;
  logic [3:0]    bidx;
  logic [7:0]    rsh;
  logic          vote, fin, accept, m0_done;
  logic [3:0]    last_idx;

  assign vote     = (v0 & v1) | (v0 & s2) | (v1 & s2);
  assign last_idx = (mode == MODE_UART8) ? 4'd9 : 4'd10;
  assign fin      = ren && st == RX_ASY && baud_tick && cnt == C_S2 && bidx == last_idx;
  assign accept   = (mode == MODE_UART8) ? (!sm2 || vote) : (!sm2 || n9);
  assign m0_done  = ren && st == RX_M0 && m0_last && bidx == 4'd7;
  assign m0_busy  = (st == RX_M0);
  assign done     = m0_done || (fin && accept);
  assign data     = rsh;
  assign rb8_wr   = fin && accept && (mode != MODE_UART8 || !sm2);
  assign rb8_val  = (mode == MODE_UART8) ? vote : n9;
  assign fe_set   = fin && !vote;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= RX_IDLE; s1 <= 1'b1; s2 <= 1'b1; v0 <= 1'b1; v1 <= 1'b1;
      n9 <= 1'b0; cnt <= '0; bidx <= '0; rsh <= '0;
    end else begin
      s1 <= rxd;
      s2 <= s1;
      if (m0_start && st == RX_IDLE) begin
        st   <= RX_M0;
        bidx <= '0;
      end else if (!ren) begin
        st <= RX_IDLE;
      end else begin
        case (st)
          RX_M0: begin
            if (m0_mid) rsh <= {rxd, rsh[7:1]};
            if (m0_last) begin
              if (bidx == 4'd7) st <= RX_IDLE;
              bidx <= bidx + 1'b1;
            end
          end
          RX_IDLE: begin
            if (mode != MODE_SHIFT && baud_tick && !s2) begin
              st   <= RX_ASY;
              cnt  <= OW'(1);
              bidx <= '0;
            end
          end
          RX_ASY: begin
            if (baud_tick) begin
              cnt <= (cnt == C_LAST) ? '0 : cnt + 1'b1;
              if (cnt == C_LAST) bidx <= bidx + 1'b1;
              if (cnt == C_S0) v0 <= s2;
              if (cnt == C_S1) v1 <= s2;
              if (cnt == C_S2) begin
                if (bidx == 4'd0 && vote) st <= RX_IDLE;
                if (bidx >= 4'd1 && bidx <= 4'd8) rsh <= {vote, rsh[7:1]};
                if (bidx == 4'd9) n9 <= vote;
                if (bidx == last_idx) st <= RX_IDLE;
              end
            end
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sport_ctl.sv
`timescale 1ns/1ps
module sport_ctl
  import sport_pkg::*;
#(
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 4,
  parameter int OVS      = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       fe_sel,
  input  logic       baud_tick,
  input  logic       rxd,
  output logic [7:0] ctl_rd,
  output logic [7:0] rx_buf,
  output logic       txd,
  output logic       sclk
);
  logic  sm0, sm1, sm2, ren, tb8, rb8, ti, ri, fe;
  logic  [7:0] rbuf;
  mode_e mode;
  logic  wr_ctl, wr_dat, m0_rx_start, nxt_sm0;
  logic  tx_busy, tx_m0_busy, ti_set;
  logic  rx_m0_busy, rx_done, rb8_wr, rb8_val, fe_set;
  logic  [7:0] rx_data;
  logic  m0_run, m0_mid, m0_last;

  assign mode        = mode_e'({sm0, sm1});
  assign wr_ctl      = wr_en && !wr_sel;
  assign wr_dat      = wr_en && wr_sel;
  assign nxt_sm0     = fe_sel ? sm0 : wr_data[7];
  assign m0_rx_start = wr_ctl && !nxt_sm0 && !wr_data[6] && wr_data[4] && !wr_data[0];
  assign m0_run      = tx_m0_busy || rx_m0_busy;

  sport_shclk #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_shclk (
    .clk(clk), .rst(rst), .run(m0_run), .fast(sm2),
    .mid(m0_mid), .last(m0_last), .sclk(sclk)
  );

  sport_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .start(wr_dat), .mode(mode), .din(wr_data),
    .bit9(tb8), .baud_tick(baud_tick), .m0_last(m0_last),
    .busy(tx_busy), .m0_busy(tx_m0_busy), .txd(txd), .ti_set(ti_set)
  );

  sport_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst(rst), .ren(ren), .mode(mode), .sm2(sm2),
    .m0_start(m0_rx_start), .m0_mid(m0_mid), .m0_last(m0_last),
    .baud_tick(baud_tick), .rxd(rxd), .m0_busy(rx_m0_busy),
    .done(rx_done), .data(rx_data), .rb8_wr(rb8_wr), .rb8_val(rb8_val),
    .fe_set(fe_set)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      {sm0, sm1, sm2, ren, tb8, rb8, ti, ri, fe} <= '0;
      rbuf <= '0;
    end else begin
      if (wr_ctl) begin
        if (fe_sel) fe <= wr_data[7];
        else        sm0 <= wr_data[7];
        {sm1, sm2, ren, tb8, rb8, ti, ri} <= wr_data[6:0];
      end
      if (ti_set) ti <= 1'b1;
      if (rx_done) begin
        ri   <= 1'b1;
        rbuf <= rx_data;
      end
      if (rb8_wr) rb8 <= rb8_val;
      if (fe_set) fe  <= 1'b1;
    end
  end

  assign ctl_rd = {(fe_sel ? fe : sm0), sm1, sm2, ren, tb8, rb8, ti, ri};
  assign rx_buf = rbuf;
endmodule

// File: rtl/sport_ctl_chk.sv
`timescale 1ns/1ps
module sport_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       wr_sel,
  input logic [7:0] ctl_rd,
  input logic       txd,
  input logic       sclk,
  input logic       tx_busy,
  input logic       m0_run
);
  // R6
  ti_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_rd[1] && !(wr_en && !wr_sel)) |=> ctl_rd[1]);

  // R6
  ri_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_rd[0] && !(wr_en && !wr_sel)) |=> ctl_rd[0]);

  // R11
  ren_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl_rd[4] && !ctl_rd[0] && !(wr_en && !wr_sel)) |=> !ctl_rd[0]);

  // R5
  txd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> txd);

  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !m0_run |-> sclk);

  // R3
  ti_source_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(ctl_rd[1]) && !$past(wr_en && !wr_sel)) |-> $past(tx_busy));
endmodule

bind sport_ctl sport_ctl_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .ctl_rd(ctl_rd),
  .txd(txd), .sclk(sclk), .tx_busy(tx_busy), .m0_run(m0_run)
);

// File: tb/sport_ctl_tb.sv
`timescale 1ns/1ps
module sport_ctl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, wr_sel = 1'b0, fe_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       baud_tick = 1'b0;
  logic       rxd = 1'b1;
  logic [7:0] ctl_rd, rx_buf;
  logic       txd, sclk;
  int         checks = 0, failures = 0;
  logic       ri_early;
  int         bcnt = 0;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    bcnt      <= (bcnt == 3) ? 0 : bcnt + 1;
    baud_tick <= (bcnt == 3);
  end

  sport_ctl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .fe_sel(fe_sel), .baud_tick(baud_tick), .rxd(rxd), .ctl_rd(ctl_rd),
    .rx_buf(rx_buf), .txd(txd), .sclk(sclk)
  );

  // {mode[1:0], sm2, tb8, data[7:0]}
  localparam logic [11:0] TXV [0:5] = '{
    {2'd0, 1'b0, 1'b0, 8'hA5},
    {2'd0, 1'b1, 1'b0, 8'h3C},
    {2'd1, 1'b0, 1'b0, 8'h96},
    {2'd2, 1'b0, 1'b1, 8'h5A},
    {2'd3, 1'b0, 1'b0, 8'hC3},
    {2'd1, 1'b0, 1'b1, 8'h01}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (!baud_tick);
    end
    #1;
  endtask

  // drive an asynchronous frame, bit 0 first, then idle one bit time
  task automatic send(input logic [10:0] fr, input int n);
    for (int b = 0; b < n; b++) begin
      rxd = fr[b];
      if (b == n - 1) begin
        wait_ticks(4);
        ri_early = ctl_rd[0];
        wait_ticks(12);
      end else begin
        wait_ticks(16);
      end
    end
    rxd = 1'b1;
    wait_ticks(16);
  endtask

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog act=timeout exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 ctl", ctl_rd, 8'h00);
    check("R1 buf", rx_buf, 8'h00);
    check("R1 txd", txd, 1'b1);
    check("R1 sclk", sclk, 1'b1);

    // transmit vector table
    for (int v = 0; v < 6; v++) begin
      logic [1:0] md;
      logic       s2b, t8;
      logic [7:0] d;
      md = TXV[v][11:10]; s2b = TXV[v][9]; t8 = TXV[v][8]; d = TXV[v][7:0];
      wr(1'b0, {md, s2b, 1'b0, t8, 3'b000});
      check("R6 ti cleared by write", ctl_rd[1], 1'b0);
      wr(1'b1, d);
      if (md == 2'd0) begin
        int div, half;
        div  = s2b ? 4 : 12;
        half = div / 2;
        check("R2 sclk low at bit start", sclk, 1'b0);
        for (int k = 0; k < 8; k++) begin
          repeat (half) @(posedge clk);
          #1;
          check("R3 mode0 txd bit", txd, d[k]);
          check("R2 sclk high mid bit", sclk, 1'b1);
          if (k == 7) begin
            repeat (div - half - 1) @(posedge clk);
            #1;
            check("R2 ti low one clock early", ctl_rd[1], 1'b0);
            @(posedge clk);
            #1;
            check("R3 ti at end of 8th bit", ctl_rd[1], 1'b1);
          end else begin
            repeat (div - half) @(posedge clk);
            #1;
          end
        end
      end else begin
        logic [10:0] fr;
        int nb;
        if (md == 2'd1) begin fr = {2'b11, d, 1'b0}; nb = 10; end
        else            begin fr = {1'b1, t8, d, 1'b0}; nb = 11; end
        for (int b = 0; b < nb; b++) begin
          wait_ticks(8);
          check("R5 async txd bit", txd, fr[b]);
          if (b == nb - 2) check("R6 ti low before stop", ctl_rd[1], 1'b0);
          wait_ticks(8);
          if (b == nb - 2) check("R6 ti at stop start", ctl_rd[1], 1'b1);
        end
        check("R5 txd idle high", txd, 1'b1);
      end
      repeat (3) @(posedge clk);
      #1;
      check("R6 ti held", ctl_rd[1], 1'b1);
    end
    wr(1'b0, 8'h00);

    // R4 mode 0 receive, fast divider
    wr(1'b0, 8'h30);
    for (int k = 0; k < 8; k++) begin
      rxd = 8'hB2 >> k;
      repeat (4) @(posedge clk);
      #1;
    end
    rxd = 1'b1;
    check("R4 mode0 ri", ctl_rd[0], 1'b1);
    check("R4 mode0 buf", rx_buf, 8'hB2);
    wr(1'b0, 8'h20);
    check("R6 ri cleared by write", ctl_rd[0], 1'b0);

    // R7 mode 1, SM2=0
    wr(1'b0, 8'h50);
    send({2'b11, 8'h6B, 1'b0}, 10);
    check("R7 ri not set early in stop", ri_early, 1'b0);
    check("R7 ri", ctl_rd[0], 1'b1);
    check("R7 buf", rx_buf, 8'h6B);
    check("R7 rb8 holds stop", ctl_rd[2], 1'b1);
    wr(1'b0, 8'h50);

    // R8 mode 1, SM2=1, bad stop bit; R10 framing flag
    wr(1'b0, 8'h70);
    send({2'b10, 8'h11, 1'b0}, 10);
    check("R8 ri blocked", ctl_rd[0], 1'b0);
    check("R8 buf kept", rx_buf, 8'h6B);
    check("R10 bit7 is mode with fe_sel=0", ctl_rd[7], 1'b0);
    fe_sel = 1'b1;
    #1;
    check("R10 bit7 shows framing flag", ctl_rd[7], 1'b1);
    wr(1'b0, 8'h70);
    check("R10 framing flag cleared, mode kept", ctl_rd, 8'h70);
    fe_sel = 1'b0;
    send({2'b11, 8'h2D, 1'b0}, 10);
    check("R8 good stop accepted", ctl_rd[0], 1'b1);
    check("R8 buf", rx_buf, 8'h2D);

    // R9 modes 2/3
    wr(1'b0, 8'hF0);
    send({1'b1, 1'b0, 8'h44, 1'b0}, 11);
    check("R9 ninth=0 filtered", ctl_rd[0], 1'b0);
    check("R9 buf kept", rx_buf, 8'h2D);
    send({1'b1, 1'b1, 8'h81, 1'b0}, 11);
    check("R9 ninth=1 accepted", ctl_rd[0], 1'b1);
    check("R9 buf", rx_buf, 8'h81);
    check("R9 rb8", ctl_rd[2], 1'b1);
    wr(1'b0, 8'hB0);
    check("R9 rb8 cleared", ctl_rd[2], 1'b0);
    send({1'b1, 1'b1, 8'h7E, 1'b0}, 11);
    check("R9 mode2 ri", ctl_rd[0], 1'b1);
    check("R9 mode2 buf", rx_buf, 8'h7E);
    check("R9 mode2 rb8", ctl_rd[2], 1'b1);

    // R11 reception disabled
    wr(1'b0, 8'h40);
    send({2'b11, 8'h99, 1'b0}, 10);
    check("R11 ri stays low", ctl_rd[0], 1'b0);
    check("R11 buf kept", rx_buf, 8'h7E);

    // R12 false start, then a good frame
    wr(1'b0, 8'h50);
    rxd = 1'b0;
    wait_ticks(3);
    rxd = 1'b1;
    wait_ticks(32);
    check("R12 false start ignored ri", ctl_rd[0], 1'b0);
    check("R12 false start ignored buf", rx_buf, 8'h7E);
    send({2'b11, 8'h5C, 1'b0}, 10);
    check("R12 next frame ri", ctl_rd[0], 1'b1);
    check("R12 next frame buf", rx_buf, 8'h5C);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule